// File: doc/BRIEF.md
# Two-Way Instruction Tag Lookup Model

This block models only the tag side of a two-way set-associative instruction cache. Each request carries a byte address and a byte count. The block takes it over a valid/ready handshake and decides whether the lines it touches are present. Each set holds two tags ordered by recency. A lookup refreshes that order and, on a miss, replaces the older tag. There are no data, no valid bits and no line fill. After reset every stored tag is zero, so an address whose tag field is zero hits from the start.

An access whose last byte falls in the next line needs two lookups, one per cycle, and the block holds `req_ready` low between them. However many of the touched lines miss, one access produces at most one miss. The miss increments a saturating counter and raises `nl_valid` for one cycle, carrying the original address and size towards the next level. An access that cannot be mapped onto one or two neighbouring sets is rejected. It sets a sticky error flag and changes nothing else.

Top module: `lru2_tag_probe`

## Requirements
- R1: With the default geometry (64 KiB, 64-byte lines, 2 ways) the set index is address bits [14:6] and the tag is address bits [31:15]. Sets are independent, and two tags that share an index compete for the same two entries.
- R2: After reset all tags are zero, `miss_count` is 0, `span_err` is 0, `nl_valid` is 0 and `req_ready` is 1. A first access whose tag is 0 therefore hits.
- R3: A lookup that matches the most recent entry of its set leaves both entries of the set unchanged and does not count as a miss.
- R4: A lookup that matches the older entry swaps the two entries and does not count as a miss.
- R5: On a miss, the most recent tag becomes the older entry, the requested tag becomes the most recent, and the previous older tag is lost. `miss_count` rises by one and `nl_valid` is 1 for the cycle after the deciding clock edge, with `nl_addr`/`nl_size` equal to the request's address and size.
- R6: An access whose first and last byte lie in the same set is accepted in one cycle. `req_ready` stays 1, so back-to-back requests are taken on every cycle.
- R7: When the last byte (address + size − 1) lies in the next set, the block does two lookups. The first uses the start address's set and tag at the accept edge. The second uses the last byte's set and tag on the following edge. `req_ready` is 0 for exactly that one cycle.
- R8: A two-set access counts and forwards exactly one miss if either or both lookups miss, and none if both hit. The forward appears in the cycle after the second lookup's edge.
- R9: Set 511 is followed by set 0. The second lookup of such an access uses the tag of the last byte, which is one greater than the start tag.
- R10: A size of 0 or above 8, or a pair of sets that is neither equal nor adjacent, sets the sticky `span_err` flag. The request is accepted in one cycle, no tag changes, no miss is counted and nothing is forwarded. Only reset clears `span_err`.
- R11: `miss_count` is CNT_W bits wide (default 64) and holds at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | ADDR_W (32) | Byte address of the access |
| req_size | input | SIZE_W (4) | Access length in bytes, 1 to MAX_SIZE |
| nl_valid | output | 1 | One-cycle forward of a missing access |
| nl_addr | output | ADDR_W (32) | Address of the forwarded access |
| nl_size | output | SIZE_W (4) | Size of the forwarded access |
| miss_count | output | CNT_W (64) | Saturating count of missing accesses |
| span_err | output | 1 | Sticky flag for an unmappable access |

## Verification
Directed sequences run in a single set, so that each recency rule is shown by what happens afterwards. A hit on the older entry must save that tag from the next eviction, and a miss must evict exactly the older tag. These sequences show a missing swap apart from a wrong victim. Straddling accesses are placed so that both halves miss, only the second misses, or the access wraps from set 511 to set 0. This shows double counting apart from a missed second-set update and from a wrong second tag. Random traffic over a few sets and tags, with sizes 1 to 8 and gaps between requests, is compared on every cycle against a behavioural model. Rejected sizes are followed by a probe that shows no tag was installed.

// File: rtl/lru2_pkg.sv
package lru2_pkg;

   // Position of the sequencer between the two lookups of one access.
   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } phase_e;

   // Number of sets an access covers.
   typedef enum logic [1:0] {
      SPAN_ONE = 2'd0,
      SPAN_TWO = 2'd1,
      SPAN_BAD = 2'd2
   } span_e;

endpackage

// File: rtl/lru2_addr_split.sv
module lru2_addr_split
   import lru2_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SIZE_W   = 4,
   parameter int OFF_W    = 6,
   parameter int IDX_W    = 9,
   parameter int MAX_SIZE = 8,
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic [IDX_W-1:0]  idx_a,
   output logic [TAG_W-1:0]  tag_a,
   output logic [IDX_W-1:0]  idx_b,
   output logic [TAG_W-1:0]  tag_b,
   output span_e             span
);

   logic [ADDR_W-1:0] last_byte;
   logic              size_ok;
   logic              unused_offset;

   // Last byte touched; wraps within the address width.
   assign last_byte = addr + ADDR_W'(size) - ADDR_W'(1);

   assign idx_a = addr[OFF_W +: IDX_W];
   assign tag_a = addr[ADDR_W-1 -: TAG_W];
   assign idx_b = last_byte[OFF_W +: IDX_W];
   assign tag_b = last_byte[ADDR_W-1 -: TAG_W];

   assign unused_offset = ^last_byte[OFF_W-1:0];

   assign size_ok = (size != '0) && (size <= SIZE_W'(MAX_SIZE));

   always_comb begin
      if (!size_ok)
         span = SPAN_BAD;
      else if (idx_b == idx_a)
         span = SPAN_ONE;
      else if (idx_b == idx_a + IDX_W'(1))
         span = SPAN_TWO;
      else
         span = SPAN_BAD;
   end

endmodule

// File: rtl/lru2_tag_array.sv
module lru2_tag_array #(
   parameter int SETS  = 512,
   parameter int IDX_W = 9,
   parameter int TAG_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] look_idx,
   input  logic [TAG_W-1:0] look_tag,
   input  logic             upd_en,
   output logic             hit_mru,
   output logic             hit_lru
);

   logic [TAG_W-1:0] mru_q [SETS];
   logic [TAG_W-1:0] lru_q [SETS];
   logic [TAG_W-1:0] mru_rd;
   logic [TAG_W-1:0] lru_rd;

   assign mru_rd  = mru_q[look_idx];
   assign lru_rd  = lru_q[look_idx];
   assign hit_mru = (look_tag == mru_rd);
   assign hit_lru = !hit_mru && (look_tag == lru_rd);

   // One pair of tag registers per set; only the addressed set moves,
   // and only when the lookup did not match its most recent entry.
   for (genvar g = 0; g < SETS; g++) begin : g_set
      logic sel;
      assign sel = upd_en && (look_idx == IDX_W'(g)) && !hit_mru;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mru_q[g] <= '0;
            lru_q[g] <= '0;
         end else if (sel) begin
            lru_q[g] <= mru_q[g];
            mru_q[g] <= look_tag;
         end
      end
   end

endmodule

// File: rtl/lru2_miss_ctr.sv
module lru2_miss_ctr #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (bump && (count != TOP))
         count <= count + CNT_W'(1);
   end

endmodule

// File: rtl/lru2_tag_probe.sv
module lru2_tag_probe
   import lru2_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int SIZE_W      = 4,
   parameter int CACHE_BYTES = 65536,
   parameter int LINE_BYTES  = 64,
   parameter int MAX_SIZE    = 8,
   parameter int CNT_W       = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   output logic              nl_valid,
   output logic [ADDR_W-1:0] nl_addr,
   output logic [SIZE_W-1:0] nl_size,
   output logic [CNT_W-1:0]  miss_count,
   output logic              span_err
);

   localparam int WAYS  = 2;
   localparam int SETS  = CACHE_BYTES / (LINE_BYTES * WAYS);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

   // Elaboration-time parameter checks.
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 2) begin : g_chk_line
      $error("lru2_tag_probe: LINE_BYTES must be a power of two");
   end
   if (CACHE_BYTES % (LINE_BYTES * WAYS) != 0) begin : g_chk_cache
      $error("lru2_tag_probe: CACHE_BYTES must be a multiple of two lines");
   end
   if ((SETS & (SETS - 1)) != 0 || SETS < 2) begin : g_chk_sets
      $error("lru2_tag_probe: set count must be a power of two, at least 2");
   end
   if (MAX_SIZE < 1 || MAX_SIZE > LINE_BYTES || MAX_SIZE >= (1 << SIZE_W)) begin : g_chk_size
      $error("lru2_tag_probe: MAX_SIZE out of range");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("lru2_tag_probe: address too narrow for the geometry");
   end
   if (CNT_W < 1) begin : g_chk_cnt
      $error("lru2_tag_probe: CNT_W must be positive");
   end

   phase_e            ph_q;
   span_e             span;
   logic [IDX_W-1:0]  idx_a, idx_b, hold_idx, look_idx;
   logic [TAG_W-1:0]  tag_a, tag_b, hold_tag, look_tag;
   logic              hold_miss;
   logic [ADDR_W-1:0] hold_addr;
   logic [SIZE_W-1:0] hold_size;
   logic              hit_mru, hit_lru, look_miss;
   logic              accept, in_second, upd_en, fire;

   lru2_addr_split #(
      .ADDR_W   (ADDR_W),
      .SIZE_W   (SIZE_W),
      .OFF_W    (OFF_W),
      .IDX_W    (IDX_W),
      .MAX_SIZE (MAX_SIZE)
   ) u_split (
      .addr  (req_addr),
      .size  (req_size),
      .idx_a (idx_a),
      .tag_a (tag_a),
      .idx_b (idx_b),
      .tag_b (tag_b),
      .span  (span)
   );

   assign in_second = (ph_q == PH_SECOND);
   assign req_ready = !in_second;
   assign accept    = req_valid && req_ready;

   // Single lookup port: the held second set wins while it is pending.
   assign look_idx  = in_second ? hold_idx : idx_a;
   assign look_tag  = in_second ? hold_tag : tag_a;
   assign upd_en    = in_second || (accept && span != SPAN_BAD);

   lru2_tag_array #(
      .SETS  (SETS),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .look_idx (look_idx),
      .look_tag (look_tag),
      .upd_en   (upd_en),
      .hit_mru  (hit_mru),
      .hit_lru  (hit_lru)
   );

   assign look_miss = !hit_mru && !hit_lru;

   always_comb begin
      fire = 1'b0;
      if (in_second)
         fire = hold_miss || look_miss;
      else if (accept && span == SPAN_ONE)
         fire = look_miss;
   end

   // Sequencer and held second-half context.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= PH_FIRST;
         hold_idx  <= '0;
         hold_tag  <= '0;
         hold_miss <= 1'b0;
         hold_addr <= '0;
         hold_size <= '0;
      end else if (in_second) begin
         ph_q <= PH_FIRST;
      end else if (accept && span == SPAN_TWO) begin
         ph_q      <= PH_SECOND;
         hold_idx  <= idx_b;
         hold_tag  <= tag_b;
         hold_miss <= look_miss;
         hold_addr <= req_addr;
         hold_size <= req_size;
      end
   end

   // Forward port and sticky error flag.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nl_valid <= 1'b0;
         nl_addr  <= '0;
         nl_size  <= '0;
         span_err <= 1'b0;
      end else begin
         nl_valid <= fire;
         if (fire) begin
            nl_addr <= in_second ? hold_addr : req_addr;
            nl_size <= in_second ? hold_size : req_size;
         end
         if (accept && span == SPAN_BAD)
            span_err <= 1'b1;
      end
   end

   lru2_miss_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (fire),
      .count (miss_count)
   );

endmodule

// File: rtl/lru2_tag_probe_chk.sv
module lru2_tag_probe_chk #(
   parameter int SIZE_W   = 4,
   parameter int MAX_SIZE = 8,
   parameter int CNT_W    = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [SIZE_W-1:0] req_size,
   input logic              nl_valid,
   input logic [SIZE_W-1:0] nl_size,
   input logic [CNT_W-1:0]  miss_count,
   input logic              span_err
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   // R7: the stall between the two lookups lasts one cycle.
   assert_stall_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> req_ready);

   // R8: accepting a straddling access forwards nothing at its first edge.
   assert_no_fwd_first_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> !nl_valid);

   // R10: a rejected size raises the flag and produces no miss.
   assert_bad_size_rejected_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_size == '0 || req_size > SIZE_W'(MAX_SIZE)))
      |=> (span_err && !nl_valid && $stable(miss_count)));

   // R10: the error flag never falls outside reset.
   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      span_err |=> span_err);

   // R5: each forward moves the counter by exactly one below the top.
   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (nl_valid && $past(miss_count) != CNT_TOP) |-> (miss_count == $past(miss_count) + CNT_W'(1)));

   // R5: without a forward the counter does not move.
   assert_count_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !nl_valid |-> $stable(miss_count));

   // R5: a forwarded size is always a legal one.
   assert_fwd_size_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      nl_valid |-> (nl_size != '0 && nl_size <= SIZE_W'(MAX_SIZE)));

   // R11: the counter stays at its top value.
   assert_count_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_count == CNT_TOP) |=> (miss_count == CNT_TOP));

endmodule

bind lru2_tag_probe lru2_tag_probe_chk #(
   .SIZE_W   (SIZE_W),
   .MAX_SIZE (MAX_SIZE),
   .CNT_W    (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_size   (req_size),
   .nl_valid   (nl_valid),
   .nl_size    (nl_size),
   .miss_count (miss_count),
   .span_err   (span_err)
);

// File: tb/lru2_tag_probe_tb.sv
`timescale 1ns/1ps
module lru2_tag_probe_tb;

   localparam int CNT_W   = 4;          // small so saturation is reachable
   localparam int NSETS   = 512;
   localparam int CNT_TOP = (1 << CNT_W) - 1;
   localparam int WD_LIM  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_size = '0;
   logic        nl_valid;
   logic [31:0] nl_addr;
   logic [3:0]  nl_size;
   logic [CNT_W-1:0] miss_count;
   logic        span_err;

   always #4 clk = ~clk;   // 125 MHz

   lru2_tag_probe #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size),
      .nl_valid(nl_valid), .nl_addr(nl_addr), .nl_size(nl_size),
      .miss_count(miss_count), .span_err(span_err)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   string cur_req  = "R2";
   bit    done     = 0;

   // ---------------- behavioural reference ----------------
   int          m_new [NSETS];
   int          m_old [NSETS];
   int          m_cnt;
   bit          m_err, m_pend, m_nl, p_miss;
   int          p_set, p_tag;
   logic [31:0] m_nl_addr, p_addr;
   logic [3:0]  m_nl_size, p_size;

   function automatic bit probe(int s, int t);
      if (m_new[s] == t) return 0;
      if (m_old[s] == t) begin
         m_old[s] = m_new[s];
         m_new[s] = t;
         return 0;
      end
      m_old[s] = m_new[s];
      m_new[s] = t;
      return 1;
   endfunction

   task automatic forward(logic [31:0] a, logic [3:0] s);
      m_nl = 1;
      m_nl_addr = a;
      m_nl_size = s;
      if (m_cnt < CNT_TOP) m_cnt++;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_new[i]) begin m_new[i] = 0; m_old[i] = 0; end
         m_cnt = 0; m_err = 0; m_pend = 0; m_nl = 0;
      end else begin
         m_nl = 0;
         if (m_pend) begin
            bit mm;
            mm = probe(p_set, p_tag);
            if (mm || p_miss) forward(p_addr, p_size);
            m_pend = 0;
         end else if (req_valid) begin
            logic [31:0] lastb;
            int s1, s2, t1, t2;
            lastb = req_addr + {28'd0, req_size} - 32'd1;
            s1 = int'(req_addr[14:6]);  t1 = int'(req_addr[31:15]);
            s2 = int'(lastb[14:6]);     t2 = int'(lastb[31:15]);
            if (req_size == 0 || req_size > 8) m_err = 1;
            else if (s1 == s2) begin
               if (probe(s1, t1)) forward(req_addr, req_size);
            end else if (s2 == (s1 + 1) % NSETS) begin
               p_miss = probe(s1, t1);
               p_set = s2; p_tag = t2; p_addr = req_addr; p_size = req_size;
               m_pend = 1;
            end else m_err = 1;
         end
      end
   end

   // ---------------- checking ----------------
   task automatic check(bit ok, string tag, string what, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(req_ready == !m_pend, cur_req, "req_ready", req_ready, !m_pend);
         check(nl_valid == m_nl, cur_req, "nl_valid", nl_valid, m_nl);
         if (m_nl) begin
            check(nl_addr == m_nl_addr, cur_req, "nl_addr", nl_addr, m_nl_addr);
            check(nl_size == m_nl_size, cur_req, "nl_size", nl_size, m_nl_size);
         end
         check(int'(miss_count) == m_cnt, cur_req, "miss_count", miss_count, m_cnt);
         check(span_err == m_err, cur_req, "span_err", span_err, m_err);
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [31:0] mk(int t, int s, int o);
      return 32'((t << 15) | (s << 6) | o);
   endfunction

   task automatic send(logic [31:0] a, logic [3:0] s);
      bit rdy;
      req_valid = 1'b1;
      req_addr  = a;
      req_size  = s;
      do begin
         rdy = req_ready;
         @(negedge clk);
      end while (!rdy);
      req_valid = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (WD_LIM) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", WD_LIM, WD_LIM);
         finish_run();
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R2: reset state at the ports
      check(req_ready == 1, "R2", "ready after reset", req_ready, 1);
      check(miss_count == 0, "R2", "count after reset", miss_count, 0);
      check(span_err == 0, "R2", "err after reset", span_err, 0);
      check(nl_valid == 0, "R2", "nl after reset", nl_valid, 0);
      send(mk(0, 5, 0), 4);  idle(2);
      check(miss_count == 0, "R2", "zero tag hits after reset", miss_count, 0);

      cur_req = "R5";
      send(mk(3, 5, 0), 1);
      check(nl_valid == 1 && nl_addr == mk(3, 5, 0) && nl_size == 1, "R5",
            "forward pulse", nl_addr, mk(3, 5, 0));
      idle(1);
      check(miss_count == 1, "R5", "first miss counted", miss_count, 1);

      cur_req = "R3";
      send(mk(3, 5, 8), 2);  idle(2);
      check(miss_count == 1, "R3", "recent-entry hit", miss_count, 1);

      cur_req = "R4";
      send(mk(0, 5, 0), 1);   // older-entry hit, swap
      send(mk(7, 5, 0), 1);   // miss evicts tag 3
      send(mk(0, 5, 0), 1);   // survives only if swapped
      idle(2);
      check(miss_count == 2, "R4", "swapped tag kept", miss_count, 2);
      cur_req = "R5";
      send(mk(3, 5, 0), 1);   // evicted earlier: miss
      send(mk(7, 5, 0), 1);   // older victim now: miss
      idle(2);
      check(miss_count == 4, "R5", "older entry evicted", miss_count, 4);

      cur_req = "R1";
      send(mk(3, 6, 0), 1);   // other set: miss
      send(mk(7, 5, 32), 1);  // set 5 undisturbed
      idle(2);
      check(miss_count == 5, "R1", "sets independent", miss_count, 5);

      cur_req = "R6";
      send(mk(3, 6, 1), 1);
      send(mk(7, 5, 2), 3);
      send(mk(8, 5, 0), 1);
      idle(2);
      check(miss_count == 6, "R6", "back-to-back", miss_count, 6);

      cur_req = "R8";
      send(mk(2, 10, 60), 8);  // both halves miss
      idle(2);
      check(miss_count == 7, "R8", "one miss per straddle", miss_count, 7);
      cur_req = "R7";
      send(mk(2, 11, 0), 1);   // second set was filled
      idle(2);
      check(miss_count == 7, "R7", "second set updated", miss_count, 7);
      cur_req = "R8";
      send(mk(2, 11, 60), 8);  // only second half misses
      send(mk(2, 12, 8), 1);
      idle(2);
      check(miss_count == 8, "R8", "second-half miss", miss_count, 8);

      cur_req = "R9";
      send(mk(4, 511, 60), 8); // tag 4 in set 511, tag 5 in set 0
      send(mk(5, 0, 0), 1);
      send(mk(4, 511, 0), 1);
      idle(2);
      check(miss_count == 9, "R9", "wrap uses next tag", miss_count, 9);

      cur_req = "R10";
      send(mk(9, 20, 0), 0);
      idle(1);
      check(span_err == 1, "R10", "size 0 flagged", span_err, 1);
      send(mk(9, 20, 0), 9);
      send(mk(9, 20, 0), 1);   // nothing installed: miss
      idle(2);
      check(miss_count == 10, "R10", "rejected left no tag", miss_count, 10);
      check(span_err == 1, "R10", "flag sticky", span_err, 1);

      cur_req = "R11";
      for (int i = 0; i < 1500; i++) begin
         int t, s, o;
         t = int'($urandom % 4);
         s = ($urandom % 8 == 0) ? 511 : 100 + int'($urandom % 4);
         o = int'($urandom % 64);
         send(mk(t, s, o), 4'(1 + $urandom % 8));
         if ($urandom % 3 == 0) idle(int'($urandom % 3));
      end
      idle(3);
      check(miss_count == CNT_TOP, "R11", "counter saturated", miss_count, CNT_TOP);
      finish_run();
   end

endmodule